// File: doc/BRIEF.md
# Software-Stepped Two-Wire Bus Master

This block is a byte-level master for a two-wire serial bus (I2C style), driven one step at a time by firmware. Software issues one command (START, write a byte, read a byte, STOP) and the block performs the matching bus event. When the event completes, the block raises an interrupt flag and publishes a status code. It then parks the bus with the clock line held low until software hands over the next command. The next command clears the flag. Nothing runs from a byte count: every address byte, data byte and start condition is its own software step. A repeated START is allowed in place of STOP, so a register write can be followed by a read without giving up the bus.

The clock line is timed by a divider. Each half period of SCL lasts `8 + divisor * scale` system clocks, where `scale` is 1, 4, 16 or 64. This makes the SCL frequency `clk / (16 + 2*divisor*scale)`. Both lines are open-drain. A line output of 1 means the line is released; the bus pulls it high.

Top module: `twm_step_master`

## Requirements
- R1: After reset, `sclLine` and `sdaLine` are 1 (released), `irqFlag` is 0 and `statusCode` is 0xF8 (idle).
- R2: A START command (`cmdOp`=0) given while the bus is idle does two things. First, SDA falls while SCL stays high. Then SCL falls and `irqFlag` sets with status 0x08. The flag is visible exactly H cycles after the command is sampled.
- R3: The half period H is 8 + divisor × {1,4,16,64}[prescSel] clocks. A write or read byte (`cmdOp`=1 or 2) takes 18 half periods from the command to the flag.
- R4: While `irqFlag` is 1 and no command is given, the outputs hold still. SCL stays low, and SDA and `statusCode` do not change.
- R5: The first write after a START or repeated START is the address byte. If its bit 0 is 0 (write), the status is 0x18 on ACK and 0x20 on NACK. If bit 0 is 1 (read), the status is 0x40 on ACK and 0x48 on NACK.
- R6: Each later write byte is sent MSB first. The status is 0x28 if the slave acknowledges and 0x30 if it does not.
- R7: A read byte releases SDA for eight clocks and shifts the bus into `rxData`, MSB first. On the ninth clock the block drives SDA low (ACK) if `ackSel` was 1 when the command was given, and releases it (NACK) if `ackSel` was 0. The status is 0x50 for ACK and 0x58 for NACK.
- R8: A START given while the flag is set produces a repeated START, with status 0x10. The byte after it is treated as an address byte again.
- R9: A STOP (`cmdOp`=3) makes SDA rise while SCL is high. After it, `irqFlag` stays 0, `statusCode` returns to 0xF8 and both lines end at 1.
- R10: Some commands are ignored. Any command given during a transfer (flag clear, bus busy) has no effect, and so does any non-START command given while idle.
- R11: Bits [2:0] of `statusCode` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | One-cycle command strobe |
| cmdOp | input | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmdData | input | 8 | Byte to write (address byte: bit 0 is the direction) |
| ackSel | input | 1 | For READ: 1 returns ACK, 0 returns NACK |
| divisor | input | DIV_W | Bit-rate divisor |
| prescSel | input | 2 | Scale select: 1, 4, 16, 64 |
| sdaIn | input | 1 | Sampled SDA bus level |
| sclLine | output | 1 | SCL drive (0 pulls low, 1 releases) |
| sdaLine | output | 1 | SDA drive (0 pulls low, 1 releases) |
| irqFlag | output | 1 | Event flag; the bus is held while it is set |
| statusCode | output | 8 | Event status, low three bits zero |
| rxData | output | 8 | Last byte shifted in from the bus |

## Verification
The bench works out when each result is due. A START from idle is due H cycles after the command edge. A repeated START takes 3H, each byte takes 18H, and a STOP has returned the lines high after 3H. The bench counts clock edges from the edge that samples the command and compares the count with these figures, using two divider settings. A scoreboard queue holds the expected status of each flag rise, and the monitor compares it at the first falling clock edge where the flag is seen set. Ignored commands are checked at the ports: the lines, the flag and the byte the slave model received are examined before the next command.

// File: rtl/twm_pkg.sv
package twm_pkg;
  localparam int BYTE_BITS = 8;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } cmdOp_e;

  typedef enum logic [1:0] {
    SDA_REL = 2'd0,
    SDA_LOW = 2'd1,
    SDA_BIT = 2'd2
  } sdaSrc_e;

  typedef struct packed {
    logic    run;
    logic    load;
    logic    shift;
    logic    sclSet;
    logic    sclVal;
    logic    sdaSet;
    sdaSrc_e sdaSrc;
  } dpStrobe_t;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_AW_NACK = 8'h20;
  localparam logic [7:0] ST_TX_ACK  = 8'h28;
  localparam logic [7:0] ST_TX_NACK = 8'h30;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_AR_NACK = 8'h48;
  localparam logic [7:0] ST_RX_ACK  = 8'h50;
  localparam logic [7:0] ST_RX_NACK = 8'h58;
  localparam logic [7:0] ST_IDLE    = 8'hF8;
endpackage

// File: rtl/twm_datapath.sv
module twm_datapath
  import twm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       prescSel,
  input  logic [7:0]       loadData,
  input  logic             sdaIn,
  output logic             tick,
  output logic [7:0]       rxData,
  output logic             sclLine,
  output logic             sdaLine
);
  // largest scale is 2^6, plus headroom for the constant part
  localparam int CNT_W = DIV_W + 7;

  logic [CNT_W-1:0] halfLim;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       shr;
  logic             bitVal;

  always_comb begin
    halfLim = CNT_W'(7) + (CNT_W'(divisor) << {prescSel, 1'b0});
  end

  assign tick = strb.run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!strb.run || cnt == '0) begin
      cnt <= halfLim;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shr <= '0;
    end else if (strb.load) begin
      shr <= loadData;
    end else if (strb.shift) begin
      shr <= {shr[6:0], sdaIn};
    end
  end

  // bit to place on SDA, taken from the value the shifter holds after this edge
  always_comb begin
    if (strb.load)       bitVal = loadData[7];
    else if (strb.shift) bitVal = shr[6];
    else                 bitVal = shr[7];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclLine <= 1'b1;
      sdaLine <= 1'b1;
    end else begin
      if (strb.sclSet) sclLine <= strb.sclVal;
      if (strb.sdaSet) begin
        case (strb.sdaSrc)
          SDA_LOW: sdaLine <= 1'b0;
          SDA_BIT: sdaLine <= bitVal;
          default: sdaLine <= 1'b1;
        endcase
      end
    end
  end

  assign rxData = shr;
endmodule

// File: rtl/twm_control.sv
module twm_control
  import twm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       addrDir,
  input  logic       ackSel,
  input  logic       tick,
  input  logic       sdaIn,
  output dpStrobe_t  strb,
  output logic       irqFlag,
  output logic [7:0] statusCode
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_RS1, S_RS2, S_BLO, S_BHI,
    S_STOP1, S_STOP2, S_STOP3, S_HOLD
  } state_e;

  state_e           state, nState;
  logic [CNT_W-1:0] bitCnt, nBit;
  logic             isRead, nRead;
  logic             isAddr, nAddr;
  logic             addrRd, nAddrRd;
  logic             ackReg, nAck;
  logic             repStart, nRep;
  logic             nFlag;
  logic [7:0]       nStatus;
  logic             ackNow;

  assign ackNow = !sdaIn;

  always_comb begin
    nState  = state;
    nBit    = bitCnt;
    nRead   = isRead;
    nAddr   = isAddr;
    nAddrRd = addrRd;
    nAck    = ackReg;
    nRep    = repStart;
    nFlag   = irqFlag;
    nStatus = statusCode;
    strb        = '0;
    strb.sdaSrc = SDA_REL;
    strb.run    = (state != S_IDLE) && (state != S_HOLD);
    case (state)
      S_IDLE: if (cmdValid && cmdOp == OP_START) begin
        strb.sdaSet = 1'b1;
        strb.sdaSrc = SDA_LOW;
        nRep        = 1'b0;
        nState      = S_START;
      end
      S_START: if (tick) begin
        strb.sclSet = 1'b1;
        strb.sclVal = 1'b0;
        nFlag       = 1'b1;
        nStatus     = repStart ? ST_RSTART : ST_START;
        nAddr       = 1'b1;
        nState      = S_HOLD;
      end
      S_HOLD: if (cmdValid) begin
        nFlag       = 1'b0;
        strb.sdaSet = 1'b1;
        case (cmdOp)
          OP_START: begin
            nRep   = 1'b1;
            nState = S_RS1;
          end
          OP_WRITE: begin
            strb.load   = 1'b1;
            strb.sdaSrc = SDA_BIT;
            nRead       = 1'b0;
            nBit        = '0;
            if (isAddr) nAddrRd = addrDir;
            nState      = S_BLO;
          end
          OP_READ: begin
            nRead  = 1'b1;
            nAck   = ackSel;
            nBit   = '0;
            nState = S_BLO;
          end
          default: begin
            strb.sdaSrc = SDA_LOW;
            nState      = S_STOP1;
          end
        endcase
      end
      S_RS1: if (tick) begin
        strb.sclSet = 1'b1;
        strb.sclVal = 1'b1;
        nState      = S_RS2;
      end
      S_RS2: if (tick) begin
        strb.sdaSet = 1'b1;
        strb.sdaSrc = SDA_LOW;
        nState      = S_START;
      end
      S_BLO: if (tick) begin
        strb.sclSet = 1'b1;
        strb.sclVal = 1'b1;
        nState      = S_BHI;
      end
      S_BHI: if (tick) begin
        strb.sclSet = 1'b1;
        strb.sclVal = 1'b0;
        if (bitCnt != CNT_W'(BYTE_BITS)) begin
          strb.shift  = 1'b1;
          strb.sdaSet = 1'b1;
          nBit        = bitCnt + 1'b1;
          nState      = S_BLO;
          if (bitCnt == CNT_W'(BYTE_BITS - 1))
            strb.sdaSrc = (isRead && ackReg) ? SDA_LOW : SDA_REL;
          else
            strb.sdaSrc = isRead ? SDA_REL : SDA_BIT;
        end else begin
          nFlag  = 1'b1;
          nAddr  = 1'b0;
          nState = S_HOLD;
          if (isRead)      nStatus = ackReg ? ST_RX_ACK : ST_RX_NACK;
          else if (!isAddr) nStatus = ackNow ? ST_TX_ACK : ST_TX_NACK;
          else if (addrRd)  nStatus = ackNow ? ST_AR_ACK : ST_AR_NACK;
          else              nStatus = ackNow ? ST_AW_ACK : ST_AW_NACK;
        end
      end
      S_STOP1: if (tick) begin
        strb.sclSet = 1'b1;
        strb.sclVal = 1'b1;
        nState      = S_STOP2;
      end
      S_STOP2: if (tick) begin
        strb.sdaSet = 1'b1;
        nStatus     = ST_IDLE;
        nState      = S_STOP3;
      end
      S_STOP3: if (tick) nState = S_IDLE;
      default: nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      bitCnt     <= '0;
      isRead     <= 1'b0;
      isAddr     <= 1'b0;
      addrRd     <= 1'b0;
      ackReg     <= 1'b0;
      repStart   <= 1'b0;
      irqFlag    <= 1'b0;
      statusCode <= ST_IDLE;
    end else begin
      state      <= nState;
      bitCnt     <= nBit;
      isRead     <= nRead;
      isAddr     <= nAddr;
      addrRd     <= nAddrRd;
      ackReg     <= nAck;
      repStart   <= nRep;
      irqFlag    <= nFlag;
      statusCode <= nStatus;
    end
  end
endmodule

// File: rtl/twm_step_master.sv
module twm_step_master
  import twm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [7:0]       cmdData,
  input  logic             ackSel,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       prescSel,
  input  logic             sdaIn,
  output logic             sclLine,
  output logic             sdaLine,
  output logic             irqFlag,
  output logic [7:0]       statusCode,
  output logic [7:0]       rxData
);
  dpStrobe_t strb;
  logic      tick;

  twm_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .addrDir    (cmdData[0]),
    .ackSel     (ackSel),
    .tick       (tick),
    .sdaIn      (sdaIn),
    .strb       (strb),
    .irqFlag    (irqFlag),
    .statusCode (statusCode)
  );

  twm_datapath #(.DIV_W(DIV_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .divisor  (divisor),
    .prescSel (prescSel),
    .loadData (cmdData),
    .sdaIn    (sdaIn),
    .tick     (tick),
    .rxData   (rxData),
    .sclLine  (sclLine),
    .sdaLine  (sdaLine)
  );
endmodule

// File: rtl/twm_checker.sv
module twm_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input logic       sclLine,
  input logic       sdaLine,
  input logic       irqFlag,
  input logic [7:0] statusCode
);
  // R11
  status_low_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusCode[2:0] == 3'b000);

  // R4
  flag_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag |-> !sclLine);

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !cmdValid) |=> (irqFlag && $stable(sclLine) && $stable(sdaLine) && $stable(statusCode)));

  // R9
  stop_no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclLine && $past(sclLine) && $rose(sdaLine)) |-> (!irqFlag && statusCode == 8'hF8));

  // R10
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!irqFlag && sclLine && sdaLine && statusCode == 8'hF8 && cmdValid && cmdOp != 2'd0)
      |=> (sclLine && sdaLine && !irqFlag));

  // R2
  flag_status_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> statusCode != 8'hF8);
endmodule

bind twm_step_master twm_checker u_twm_checker (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .cmdOp      (cmdOp),
  .sclLine    (sclLine),
  .sdaLine    (sdaLine),
  .irqFlag    (irqFlag),
  .statusCode (statusCode)
);

// File: tb/twm_step_master_bench.sv
module twm_step_master_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic [7:0] cmdData = 8'h00;
  logic       ackSel = 1'b0;
  logic [7:0] divisor = 8'd2;
  logic [1:0] prescSel = 2'd0;
  logic       sdaIn;
  logic       sclLine, sdaLine, irqFlag;
  logic [7:0] statusCode, rxData;

  int checks = 0;
  int errors = 0;
  int halfCyc = 10;

  typedef struct { logic [7:0] code; string tag; } expItem_t;
  expItem_t expQ[$];

  // slave model state
  localparam logic [6:0] SLV_ADDR = 7'h52;
  logic       slvSda = 1'b1;
  logic       prevScl = 1'b1, prevSda = 1'b1, prevFlag = 1'b0;
  logic       active = 1'b0, addrPhase = 1'b0, selected = 1'b0, rdMode = 1'b0;
  logic       masterAck = 1'b0, nackWrites = 1'b0;
  int         bitIdx = 0;
  logic [7:0] sShr = 8'h00, txSh = 8'h00, txNext = 8'hA5;
  logic [7:0] slvLog[$];

  assign sdaIn = sdaLine & slvSda;

  always #2 clk = ~clk;

  twm_step_master u_twm_step_master (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .ackSel(ackSel), .divisor(divisor), .prescSel(prescSel), .sdaIn(sdaIn),
    .sclLine(sclLine), .sdaLine(sdaLine), .irqFlag(irqFlag),
    .statusCode(statusCode), .rxData(rxData)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // slave on the bus, evaluated away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (prevScl && sclLine && prevSda && !sdaIn) begin
        active = 1'b1; addrPhase = 1'b1; selected = 1'b0; rdMode = 1'b0;
        bitIdx = 0; slvSda = 1'b1;
      end else if (prevScl && sclLine && !prevSda && sdaIn) begin
        active = 1'b0; slvSda = 1'b1;
      end else if (active && !prevScl && sclLine) begin
        if (bitIdx < 8) sShr = {sShr[6:0], sdaIn};
        else masterAck = !sdaIn;
        bitIdx++;
      end else if (active && prevScl && !sclLine) begin
        if (bitIdx == 8) begin
          if (addrPhase) begin
            selected = (sShr[7:1] == SLV_ADDR);
            rdMode = sShr[0];
            if (selected) slvSda = 1'b0;
          end else if (selected && !rdMode) begin
            slvLog.push_back(sShr);
            slvSda = nackWrites;
          end else begin
            slvSda = 1'b1;
          end
        end else if (bitIdx == 9) begin
          slvSda = 1'b1;
          bitIdx = 0;
          if (selected && rdMode && (addrPhase || masterAck)) begin
            slvSda = txNext[7];
            txSh = txNext << 1;
            txNext = txNext + 8'h11;
          end
          addrPhase = 1'b0;
        end else if (bitIdx >= 1 && bitIdx <= 7 && selected && rdMode && !addrPhase) begin
          slvSda = txSh[7];
          txSh = txSh << 1;
        end
      end
    end
    prevScl = sclLine;
    prevSda = sdaIn;
  end

  // scoreboard monitor: each flag rise pops one expected status
  always @(negedge clk) begin
    if (rstN && irqFlag && !prevFlag) begin
      if (expQ.size() == 0) begin
        check(1'b0, "unexpected flag (R9)", statusCode, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(statusCode == e.code, e.tag, statusCode, e.code);
        check(statusCode[2:0] == 3'b000, "R11 status low bits", statusCode, 0);
      end
    end
    prevFlag <= irqFlag;
  end

  task automatic issue(input logic [1:0] op, input logic [7:0] data, input logic ack);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdData = data; ackSel = ack;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic step(input logic [1:0] op, input logic [7:0] data, input logic ack,
                      input logic [7:0] code, input string tag, input int expCyc);
    int cyc;
    expItem_t e;
    e.code = code; e.tag = tag;
    expQ.push_back(e);
    issue(op, data, ack);
    cyc = 0;
    while (!irqFlag) begin
      @(negedge clk);
      cyc++;
    end
    if (expCyc > 0) check(cyc == expCyc, {tag, " timing"}, cyc, expCyc);
  endtask

  task automatic stopBus(input string tag);
    issue(2'd3, 8'h00, 1'b0);
    repeat (3 * halfCyc + 2) @(negedge clk);
    check(sclLine && sdaLine, {tag, " lines idle"}, {sclLine, sdaLine}, 2'b11);
    check(!irqFlag, {tag, " flag clear"}, irqFlag, 0);
    check(statusCode == 8'hF8, {tag, " idle status"}, statusCode, 8'hF8);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(sclLine && sdaLine, "R1 lines released", {sclLine, sdaLine}, 2'b11);
    check(!irqFlag, "R1 flag low", irqFlag, 0);
    check(statusCode == 8'hF8, "R1 idle status", statusCode, 8'hF8);

    // R10: non-START command in idle is ignored
    issue(2'd1, 8'h00, 1'b0);
    repeat (40) @(negedge clk);
    check(sclLine && sdaLine && !irqFlag, "R10 idle write ignored",
          {irqFlag, sclLine, sdaLine}, 3'b011);

    // divisor 2, scale 1: H = 10
    halfCyc = 10;
    step(2'd0, 8'h00, 1'b0, 8'h08, "R2 start", halfCyc);
    // R4: held while flag set
    repeat (30) @(negedge clk);
    check(irqFlag && !sclLine, "R4 hold", {irqFlag, sclLine}, 2'b10);
    check(statusCode == 8'h08, "R4 status stable", statusCode, 8'h08);

    step(2'd1, {SLV_ADDR, 1'b0}, 1'b0, 8'h18, "R5 addr write ack", 18 * halfCyc);
    step(2'd1, 8'h3C, 1'b0, 8'h28, "R6 data ack", 18 * halfCyc);
    check(slvLog.size() > 0 && slvLog[$] == 8'h3C, "R6 byte on bus", slvLog[$], 8'h3C);

    // R10: command during a transfer is ignored
    begin
      expItem_t e;
      int cyc;
      e.code = 8'h28; e.tag = "R10 busy status";
      expQ.push_back(e);
      issue(2'd1, 8'h81, 1'b0);
      cyc = 0;
      repeat (50) begin @(negedge clk); cyc++; end
      cmdValid = 1'b1; cmdOp = 2'd3; cmdData = 8'hFF;
      @(negedge clk); cyc++;
      cmdValid = 1'b0;
      while (!irqFlag) begin @(negedge clk); cyc++; end
      check(cyc == 18 * halfCyc, "R10 busy timing", cyc, 18 * halfCyc);
      check(slvLog[$] == 8'h81, "R10 busy byte intact", slvLog[$], 8'h81);
    end

    nackWrites = 1'b1;
    step(2'd1, 8'h55, 1'b0, 8'h30, "R6 data nack", 18 * halfCyc);
    nackWrites = 1'b0;

    step(2'd0, 8'h00, 1'b0, 8'h10, "R8 repeated start", 3 * halfCyc);
    step(2'd1, {SLV_ADDR, 1'b1}, 1'b0, 8'h40, "R8 R5 addr read ack", 18 * halfCyc);
    step(2'd2, 8'h00, 1'b1, 8'h50, "R7 read ack", 18 * halfCyc);
    check(rxData == 8'hA5, "R7 first byte", rxData, 8'hA5);
    step(2'd2, 8'h00, 1'b0, 8'h58, "R7 read nack", 18 * halfCyc);
    check(rxData == 8'hB6, "R7 second byte", rxData, 8'hB6);
    stopBus("R9 stop");

    // divisor 3, scale 4: H = 20
    divisor = 8'd3; prescSel = 2'd1; halfCyc = 20;
    step(2'd0, 8'h00, 1'b0, 8'h08, "R3 start slow", halfCyc);
    step(2'd1, {7'h20, 1'b0}, 1'b0, 8'h20, "R3 R5 addr write nack", 18 * halfCyc);
    stopBus("R9 stop slow");
    step(2'd0, 8'h00, 1'b0, 8'h08, "R2 start again", halfCyc);
    step(2'd1, {SLV_ADDR, 1'b1}, 1'b0, 8'h40, "R5 addr read ack slow", 18 * halfCyc);
    step(2'd2, 8'h00, 1'b0, 8'h58, "R7 read nack slow", 18 * halfCyc);
    check(rxData == 8'hC7, "R7 third byte", rxData, 8'hC7);
    step(2'd0, 8'h00, 1'b0, 8'h10, "R8 repeated start slow", 3 * halfCyc);
    step(2'd1, {7'h20, 1'b1}, 1'b0, 8'h48, "R5 addr read nack", 18 * halfCyc);
    stopBus("R9 final stop");

    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule